// File: doc/BRIEF.md
# Paired Up/Down Event Counter with Reversal Detection

The block holds two 8-bit event counters. Each one moves up or down on its own up-event and down-event inputs. A shared free-running prescaler divides the peripheral clock, and each channel picks one of two tick rates. The event inputs count only in a cycle where that channel's tick is high. A mode bit on channel 0 joins the pair into one 16-bit counter, with channel 0 as the low byte. In that mode, channel 0's events, tick rate and reversal logic drive the whole 16-bit value.

Each channel remembers the direction of its last count. When a count goes the other way, the channel sets a sticky reversal flag. Software clears the flag over the byte bus. The direction starts as down, so the first up-count after reset already counts as a reversal. Each channel drives a level interrupt, which is high while both the channel's flag and its interrupt enable are set.

Software reaches four control bytes through a 2-bit byte address. Address 0 is channel 0 low, 1 is channel 0 high, 2 is channel 1 low and 3 is channel 1 high. Writes happen on the clock edge. Reads come back combinationally on `busRdata`.

Top module: `udcPair`

## Requirements
- R1: After reset both counts are 0, both interrupts are low, both low control bytes read 0x08 and both high control bytes read 0x00.
- R2: In the high control byte, bit 4 selects the tick rate: 0 ticks once every 2 clock cycles and 1 ticks once every 8. The event inputs are sampled only in tick cycles and are ignored in all other cycles.
- R3: On a tick, an up event alone adds 1 and a down event alone subtracts 1. An 8-bit count wraps modulo 256. Up and down together in one tick change neither the count nor the direction state.
- R4: The direction state resets to down, so the first up-count after reset sets the reversal flag (high byte bit 6).
- R5: The reversal flag is set by every count whose direction differs from the previous count's direction, and it stays set through any later counts.
- R6: Writing 0 to bit 6 of a high control byte clears that channel's flag, and writing 1 leaves it unchanged. If a reversal sets the flag in the same cycle as a clearing write, the flag ends up set.
- R7: A channel's interrupt is a level equal to its flag AND its enable (high byte bit 5). It is low in the cycle after a write that clears the enable bit, or that clears the flag with no reversal in the same cycle.
- R8: When bit 7 of channel 0's high byte is 1, the two counts form one 16-bit counter with channel 0 as the low byte. A carry or borrow out of the low byte moves the high byte in the same tick, and the 16-bit value wraps modulo 65536.
- R9: In 16-bit mode, channel 1's events, low-byte clear writes, direction state and flag have no effect. Bit 7 of channel 1's high byte is stored and read back, and it changes nothing.
- R10: Low control bytes always read 0x08. Writing a low byte with bit 3 at 0 zeroes that channel's count in the next cycle, and the clear takes precedence over a count in the same tick. In 16-bit mode, clearing channel 0 zeroes all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Byte write strobe |
| busAddr | input | 2 | Control byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| upEvt | input | 2 | Up-count event per channel |
| downEvt | input | 2 | Down-count event per channel |
| cntLo | output | CNT_W | Channel 0 count (low byte when chained) |
| cntHi | output | CNT_W | Channel 1 count (high byte when chained) |
| irq | output | 2 | Reversal interrupt per channel |

## Verification
Three pairs of functions can fall in the same cycle. A reversing count and a software write that clears the flag can land on one tick. The bench forces this by waiting until its model's prescaler phase says the next edge is a tick, then driving the clearing write together with an event opposite to the stored direction; the flag must stay set. A low-byte clear can coincide with a count, and an up and a down event can coincide. Random traffic produces both collisions many times, and every cycle the result is compared with the reference model.

// File: rtl/udcPkg.sv
package udcPkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic           chain;
    logic [NCH-1:0] up;
    logic [NCH-1:0] dn;
    logic [NCH-1:0] clr;
  } udcStrobe_t;
endpackage

// File: rtl/udcCell.sv
module udcCell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
    else if (dec) q <= q - 1'b1;
  end

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (q == '0));
endmodule

// File: rtl/udcData.sv
module udcData
  import udcPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  udcStrobe_t       strb,
  output logic [CNT_W-1:0] cntLo,
  output logic [CNT_W-1:0] cntHi
);
  logic carryUp, carryDn, hiInc, hiDec, hiClr;

  always_comb begin
    carryUp = strb.chain && strb.up[0] && (&cntLo);
    carryDn = strb.chain && strb.dn[0] && (cntLo == '0);
    hiInc   = strb.chain ? carryUp   : strb.up[1];
    hiDec   = strb.chain ? carryDn   : strb.dn[1];
    hiClr   = strb.chain ? strb.clr[0] : strb.clr[1];
  end

  udcCell #(.W(CNT_W)) u_lo (
    .clk(clk), .rstN(rstN), .clr(strb.clr[0]),
    .inc(strb.up[0]), .dec(strb.dn[0]), .q(cntLo)
  );

  udcCell #(.W(CNT_W)) u_hi (
    .clk(clk), .rstN(rstN), .clr(hiClr),
    .inc(hiInc), .dec(hiDec), .q(cntHi)
  );

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.up == '0 && strb.dn == '0 && strb.clr == '0) |=> ($stable(cntLo) && $stable(cntHi)));

  assert_wrap_lo_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.up[0] && !strb.clr[0] && (&cntLo)) |=> (cntLo == '0));

  assert_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.chain && strb.up[0] && !strb.clr[0] && (&cntLo)) |=> (cntHi == $past(cntHi) + 1'b1));
endmodule

// File: rtl/udcCtrl.sv
module udcCtrl
  import udcPkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [1:0]           busAddr,
  input  logic [7:0]           busWdata,
  input  logic [NCH-1:0]       upEvt,
  input  logic [NCH-1:0]       downEvt,
  output udcStrobe_t           strb,
  output logic [NCH-1:0][7:0]  hiView,
  output logic [NCH-1:0]       irq
);
  localparam int DW = $clog2(DIV_SLOW);
  localparam int FW = $clog2(DIV_FAST);

  logic [DW-1:0]  divQ;
  logic           tickFast, tickSlow;
  logic [NCH-1:0] modeQ, flagQ, ienQ, selQ, dirUpQ;
  logic [NCH-1:0] active, tick, cntEvt, dirChange, hiWr, loWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divQ <= '0;
    else       divQ <= divQ + 1'b1;
  end

  assign tickFast = &divQ[FW-1:0];
  assign tickSlow = &divQ;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign active[c]    = !(modeQ[0] && (c != 0));
    assign tick[c]      = selQ[c] ? tickSlow : tickFast;
    assign cntEvt[c]    = active[c] && tick[c] && (upEvt[c] ^ downEvt[c]);
    assign dirChange[c] = cntEvt[c] && (upEvt[c] != dirUpQ[c]);
    assign hiWr[c]      = busWe && (busAddr == 2'(2 * c + 1));
    assign loWr[c]      = busWe && (busAddr == 2'(2 * c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[c]  <= 1'b0;
        flagQ[c]  <= 1'b0;
        ienQ[c]   <= 1'b0;
        selQ[c]   <= 1'b0;
        dirUpQ[c] <= 1'b0;
      end else begin
        if (dirChange[c])                  flagQ[c] <= 1'b1;
        else if (hiWr[c] && !busWdata[6])  flagQ[c] <= 1'b0;
        if (cntEvt[c]) dirUpQ[c] <= upEvt[c];
        if (hiWr[c]) begin
          modeQ[c] <= busWdata[7];
          ienQ[c]  <= busWdata[5];
          selQ[c]  <= busWdata[4];
        end
      end
    end

    assign strb.up[c]  = cntEvt[c] && upEvt[c];
    assign strb.dn[c]  = cntEvt[c] && !upEvt[c];
    assign strb.clr[c] = loWr[c] && !busWdata[3] && active[c];
    assign hiView[c]   = {modeQ[c], flagQ[c], ienQ[c], selQ[c], 4'b0000};
    assign irq[c]      = flagQ[c] && ienQ[c];

    assert_up_after_down_R4: assert property (@(posedge clk) disable iff (!rstN)
      (cntEvt[c] && upEvt[c] && !dirUpQ[c]) |=> flagQ[c]);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[c] && !(hiWr[c] && !busWdata[6])) |=> flagQ[c]);

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (hiWr[c] && !busWdata[6] && !dirChange[c]) |=> !flagQ[c]);

    assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
      (hiWr[c] && !busWdata[5]) |=> !irq[c]);
  end

  assign strb.chain = modeQ[0];

  assert_tick_sparse_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickSlow |=> !tickSlow);

  assert_chain_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[0] |-> (strb.up[1] == 1'b0 && strb.dn[1] == 1'b0 && strb.clr[1] == 1'b0));
endmodule

// File: rtl/udcPair.sv
module udcPair
  import udcPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  input  logic [1:0]       upEvt,
  input  logic [1:0]       downEvt,
  output logic [CNT_W-1:0] cntLo,
  output logic [CNT_W-1:0] cntHi,
  output logic [1:0]       irq
);
  localparam logic [7:0] LO_VIEW = 8'h08;

  udcStrobe_t           strb;
  logic [NCH-1:0][7:0]  hiView;

  udcCtrl #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .upEvt(upEvt), .downEvt(downEvt),
    .strb(strb), .hiView(hiView), .irq(irq)
  );

  udcData #(.CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .cntLo(cntLo), .cntHi(cntHi)
  );

  always_comb begin
    if (!busAddr[0]) busRdata = LO_VIEW;
    else             busRdata = hiView[busAddr[1]];
  end
endmodule

// File: tb/udcPair_tb.sv
module udcPair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [1:0] upEvt = 2'b00;
  logic [1:0] downEvt = 2'b00;
  logic [7:0] cntLo, cntHi;
  logic [1:0] irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit started = 0;

  // reference model state
  int cntM [2];
  bit dirUpM [2], flagM [2], ienM [2], selM [2], modeM [2];
  int divM;

  udcPair u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .upEvt(upEvt),
    .downEvt(downEvt), .cntLo(cntLo), .cntHi(cntHi), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expRead(logic [1:0] a);
    int c;
    c = a[1];
    if (!a[0]) return 8'h08;
    return {modeM[c], flagM[c], ienM[c], selM[c], 4'b0000};
  endfunction

  // behavioural model, updated on each edge from the inputs held since the last falling edge
  always @(posedge clk) begin : model
    bit tickF, tickS, chain, act, tk, evt, ch;
    int v;
    bit nFlag [2];
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        cntM[c] = 0; dirUpM[c] = 0; flagM[c] = 0; ienM[c] = 0; selM[c] = 0; modeM[c] = 0;
      end
      divM = 0;
    end else begin
      cycles++;
      tickF = (divM % 2) == 1;
      tickS = (divM == 7);
      chain = modeM[0];
      for (int c = 0; c < 2; c++) begin
        act = !(chain && c == 1);
        tk  = selM[c] ? tickS : tickF;
        evt = act && tk && (upEvt[c] ^ downEvt[c]);
        ch  = evt && (upEvt[c] != dirUpM[c]);
        nFlag[c] = flagM[c];
        if (ch) nFlag[c] = 1;
        else if (busWe && busAddr == 2'(2 * c + 1) && !busWdata[6]) nFlag[c] = 0;
        if (c == 0 && chain) begin
          v = cntM[1] * 256 + cntM[0];
          if (busWe && busAddr == 2'd0 && !busWdata[3]) v = 0;
          else if (evt) v = upEvt[0] ? v + 1 : v - 1;
          v = (v + 65536) % 65536;
          cntM[0] = v % 256;
          cntM[1] = v / 256;
        end else if (act) begin
          v = cntM[c];
          if (busWe && busAddr == 2'(2 * c) && !busWdata[3]) v = 0;
          else if (evt) v = upEvt[c] ? v + 1 : v - 1;
          cntM[c] = (v + 256) % 256;
        end
        if (evt) dirUpM[c] = upEvt[c];
      end
      for (int c = 0; c < 2; c++) begin
        flagM[c] = nFlag[c];
        if (busWe && busAddr == 2'(2 * c + 1)) begin
          modeM[c] = busWdata[7]; ienM[c] = busWdata[5]; selM[c] = busWdata[4];
        end
      end
      divM = (divM + 1) % 8;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      chk("R3 count ch0", cntLo, cntM[0]);
      chk("R8 count ch1/high", cntHi, cntM[1]);
      chk("R7 irq ch0", irq[0], flagM[0] && ienM[0]);
      chk("R7 irq ch1", irq[1], flagM[1] && ienM[1]);
      chk("R6 readback", busRdata, expRead(busAddr));
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // drive at a falling edge, hold through one rising edge, return at the next falling edge
  task automatic step(bit we, logic [1:0] a, logic [7:0] wd, logic [1:0] up, logic [1:0] dn);
    busWe = we; busAddr = a; busWdata = wd; upEvt = up; downEvt = dn;
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [1:0] a);
    for (int i = 0; i < n; i++) step(0, a, 8'h00, 2'b00, 2'b00);
  endtask

  initial begin
    // R1: reset values
    #(CLK_PERIOD * 2 + 1);
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a);
      #1;
      chk("R1 reset readback", busRdata, (a % 2 == 0) ? 8'h08 : 8'h00);
    end
    chk("R1 reset cntLo", cntLo, 0);
    chk("R1 reset cntHi", cntHi, 0);
    chk("R1 reset irq", irq, 0);
    @(negedge clk);
    rstN = 1'b1;
    started = 1;

    // R4: first up-count after reset flags a reversal
    for (int i = 0; i < 6; i++) step(0, 2'd1, 8'h00, 2'b01, 2'b00);
    chk("R3 up count ch0", cntLo, 3);
    chk("R4 first up sets flag", busRdata[6], 1);
    // R6: writing 1 keeps the flag, enable interrupt
    step(1, 2'd1, 8'h60, 2'b00, 2'b00);
    chk("R6 write 1 keeps flag", busRdata[6], 1);
    chk("R7 irq with enable", irq[0], 1);
    // R6/R7: write 0 clears, irq drops next cycle
    step(1, 2'd1, 8'h20, 2'b00, 2'b00);
    chk("R6 clear flag", busRdata[6], 0);
    chk("R7 irq drops", irq[0], 0);
    // R3: up and down together cancel
    for (int i = 0; i < 6; i++) step(0, 2'd1, 8'h00, 2'b01, 2'b01);
    chk("R3 cancel count", cntLo, 3);
    chk("R3 cancel keeps direction", busRdata[6], 0);
    // R5: reversal to down sets flag, stays set
    for (int i = 0; i < 10; i++) step(0, 2'd1, 8'h00, 2'b00, 2'b01);
    chk("R3 wrap below zero", cntLo, 8'hFE);
    chk("R5 reversal flag", busRdata[6], 1);
    for (int i = 0; i < 4; i++) step(0, 2'd1, 8'h00, 2'b00, 2'b01);
    chk("R5 flag sticky", busRdata[6], 1);
    step(1, 2'd1, 8'h20, 2'b00, 2'b00);
    // R6: reversal and clear in the same cycle; set wins
    while (divM % 2 == 0) step(0, 2'd1, 8'h00, 2'b00, 2'b00);
    step(1, 2'd1, 8'h20, {1'b0, !dirUpM[0]}, {1'b0, dirUpM[0]});
    chk("R6 set wins over clear", busRdata[6], 1);
    chk("R7 irq after race", irq[0], 1);

    // R2: slow tick on ch1
    step(1, 2'd3, 8'h10, 2'b00, 2'b00);
    while (divM != 0) step(0, 2'd3, 8'h00, 2'b00, 2'b00);
    for (int i = 0; i < 16; i++) step(0, 2'd3, 8'h00, 2'b10, 2'b00);
    chk("R2 slow tick count", cntHi, 2);
    // R10: clear ch1, low byte reads 0x08
    step(1, 2'd2, 8'h00, 2'b00, 2'b00);
    chk("R10 clear ch1", cntHi, 0);
    chk("R10 low byte view", busRdata, 8'h08);
    // R9: reserved mode bit on ch1 reads back, channels stay split
    step(1, 2'd3, 8'h80, 2'b00, 2'b00);
    chk("R9 ch1 mode readback", busRdata, 8'h80 | (flagM[1] ? 8'h40 : 8'h00));
    for (int i = 0; i < 4; i++) step(0, 2'd3, 8'h00, 2'b10, 2'b00);
    chk("R9 ch1 independent", cntHi, 2);

    // R8: chained mode, wrap below zero to 0xFFFF
    step(1, 2'd1, 8'hA0, 2'b00, 2'b00);
    step(1, 2'd0, 8'h00, 2'b00, 2'b00);
    chk("R10 chained clear", {cntHi, cntLo}, 0);
    while (divM % 2 == 0) step(0, 2'd1, 8'h00, 2'b00, 2'b00);
    step(0, 2'd1, 8'h00, 2'b00, 2'b01);
    chk("R8 borrow to 0xFFFF", {cntHi, cntLo}, 16'hFFFF);
    step(0, 2'd1, 8'h00, 2'b00, 2'b00);
    step(0, 2'd1, 8'h00, 2'b01, 2'b00);
    chk("R8 carry to 0x0000", {cntHi, cntLo}, 0);
    // R9: ch1 events and ch1 clear ignored in chained mode
    for (int i = 0; i < 300; i++) step(0, 2'd3, 8'h00, 2'b10, 2'b00);
    chk("R9 ch1 events ignored", {cntHi, cntLo}, 0);
    for (int i = 0; i < 20; i++) step(0, 2'd3, 8'h00, 2'b01, 2'b00);
    step(1, 2'd2, 8'h00, 2'b00, 2'b00);
    chk("R9 ch1 clear ignored", cntHi, cntM[1]);

    // random traffic: collisions of clears, counts, reversals and flag writes
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 2'($urandom), 8'($urandom), 2'($urandom), 2'($urandom));
    end
    idle(4, 2'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule